// File: doc/BRIEF.md
# Multi-Trigger Shadow Register Update Controller

This block keeps control registers of a line-scan timing generator in two copies: a staged copy that the serial write path loads, and an active copy that drives the pattern logic downstream. A register's staged value moves to its active copy only at the moment its update class calls for. The four classes are: at once when the write word completes, at a falling edge of the frame sync, at the end of a shutter line, and at the sequence change point where the register is next referenced. Frame-class commits can be pushed back from the sync edge to a chosen line. That keeps a frame in progress intact and makes a batch of writes take effect together.

A decoded write (address, data, word-complete strobe) enters from an external serial shifter. The frame sync `vd`, the line sync `hd`, the shutter-line flag and the sequence change pulses with their region index all come from the surrounding timing logic. The block returns every active register on one packed bus. A per-region table inside the block chooses which vertical sequence each region uses. A sequence-class register commits only when a region that selects its sequence begins.

Top module: `shreg_update_ctrl`

## Requirements
- R1: A write to an immediate-class address (0x00 or 0x01) shows on its active copy in the clock cycle after the word-complete strobe.
- R2: A frame-class register (0x02 to 0x05) holds its old active value after a write. When the line-delay value is 0, it takes the staged value at the next falling edge of `vd`.
- R3: The line-delay register at 0x18 takes its low 10 bits at once. When it holds N > 0, frame-class registers commit at the Nth falling edge of `hd` after the falling edge of `vd`. This happens only once per field, and later `hd` edges in the same field commit nothing.
- R4: The region table entries (0x10 to 0x13) always commit at the falling edge of `vd`, whatever the line-delay value.
- R5: A shutter-class register (0x08 or 0x09) commits at a falling edge of `hd` only when `sg_line` is high. A falling edge of `hd` with `sg_line` low changes nothing.
- R6: The sequence-class registers are at 0x20 + 2*s + j, where s is the sequence and j is 0 or 1. They commit on a `scp_pulse` only when the active table entry of `scp_region` selects sequence s (low 2 bits). A pulse for any other region leaves them unchanged.
- R7: When a register is written more than once before its commit event, only the last value written is committed.
- R8: A write that arrives in the same cycle as the register's commit event does not commit. The value staged before it commits, and the new value waits for the next event.
- R9: A synchronous reset sets every active and staged copy to 0 and sets region entry r to the value r. It also clears all pending writes, so a later event commits nothing.
- R10: `act_o` carries register k in bits [20*k+19 : 20*k]. k runs 0-1 for immediate, 2-5 for frame, 6-7 for shutter, 8-11 for region entries 0-3, and 12-19 for 0x20-0x27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Word-complete strobe of a decoded write |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 20 | Register data of the write |
| vd | input | 1 | Frame sync level; falling edge starts a field |
| hd | input | 1 | Line sync level; falling edge ends a line |
| sg_line | input | 1 | High during the shutter-active line |
| scp_pulse | input | 1 | One-cycle sequence change point |
| scp_region | input | 2 | Index of the region starting at the pulse |
| act_o | output | 400 | All active register copies, packed |

## Verification
On every cycle the assertions check the following. An active copy changes only in a cycle where a pending commit fires. A commit delivers the value that was staged before that edge. A write always leaves its register pending. The line counter restarts at each frame edge, and a delayed frame commit fires once and then disarms. Only the bench's scenarios show the class routing itself. That covers which event reaches which address range, the region table steering sequence commits, a line delay against the count of `hd` edges, and a write racing its own commit event.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  typedef enum logic [2:0] {
    CLS_IMM,
    CLS_FRAME,
    CLS_FIELD,
    CLS_SHUT,
    CLS_SEQ
  } upd_cls_e;

  localparam int BASE_IMM    = 'h00;
  localparam int BASE_FRAME  = 'h02;
  localparam int BASE_SHUT   = 'h08;
  localparam int BASE_REGION = 'h10;
  localparam int ADDR_DELAY  = 'h18;
  localparam int BASE_SEQ    = 'h20;

  // Update class of flat register index k, given the first index of each group.
  function automatic upd_cls_e cls_of(int k, int kf, int ks, int kr, int kq);
    if (k < kf)      return CLS_IMM;
    else if (k < ks) return CLS_FRAME;
    else if (k < kr) return CLS_SHUT;
    else if (k < kq) return CLS_FIELD;
    else             return CLS_SEQ;
  endfunction

  // Bus address of flat register index k.
  function automatic int addr_of(int k, int kf, int ks, int kr, int kq);
    if (k < kf)      return BASE_IMM + k;
    else if (k < ks) return BASE_FRAME + (k - kf);
    else if (k < kr) return BASE_SHUT + (k - ks);
    else if (k < kq) return BASE_REGION + (k - kr);
    else             return BASE_SEQ + (k - kq);
  endfunction

  // Sequence that owns a sequence-class register.
  function automatic int seq_of(int k, int kq, int regs_per_seq);
    return (k - kq) / regs_per_seq;
  endfunction

endpackage

// File: rtl/shreg_events.sv
module shreg_events #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vd,
  input  logic              hd,
  input  logic              sg_line,
  input  logic [LINE_W-1:0] delay_line,
  output logic              vd_fall,
  output logic              sg_end,
  output logic              frame_go
);

  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic              vd_q;
  logic              hd_q;
  logic              hd_fall;
  logic              armed;
  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] line_nxt;

  // Saturating line advance; a field longer than the counter just parks at the top.
  function automatic logic [LINE_W-1:0] line_step(logic [LINE_W-1:0] cnt);
    return (cnt == LINE_MAX) ? cnt : cnt + 1'b1;
  endfunction

  assign vd_fall  = vd_q & ~vd;
  assign hd_fall  = hd_q & ~hd;
  assign sg_end   = hd_fall & sg_line;
  assign line_nxt = line_step(line_cnt);

  always_comb begin
    if (delay_line == '0) frame_go = vd_fall;
    else                  frame_go = armed & hd_fall & ~vd_fall & (line_nxt == delay_line);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vd_q     <= 1'b1;
      hd_q     <= 1'b1;
      line_cnt <= '0;
      armed    <= 1'b0;
    end else begin
      vd_q <= vd;
      hd_q <= hd;
      if (vd_fall) begin
        line_cnt <= '0;
        armed    <= (delay_line != '0);
      end else if (hd_fall) begin
        line_cnt <= line_nxt;
        if (frame_go) armed <= 1'b0;
      end
    end
  end

  assert_line_restart_R3: assert property (@(posedge clk) disable iff (rst)
    vd_fall |=> (line_cnt == '0));

  assert_delayed_once_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_go && !vd_fall) |=> !armed);

  assert_go_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    frame_go |-> (vd_fall || hd_fall));

endmodule

// File: rtl/shreg_cell.sv
module shreg_cell #(
  parameter int              DATA_W    = 20,
  parameter bit              IMMEDIATE = 1'b0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output logic [DATA_W-1:0] active
);

  generate
    if (IMMEDIATE) begin : g_imm
      always_ff @(posedge clk) begin
        if (rst)         active <= RST_VAL;
        else if (wr_hit) active <= wr_data;
      end

      assert_imm_write_R1: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (active == $past(wr_data)));

      logic unused_commit;
      assign unused_commit = commit;
    end else begin : g_shadow
      logic [DATA_W-1:0] staged;
      logic              pend;
      logic              fire;

      assign fire = commit & pend;

      always_ff @(posedge clk) begin
        if (rst) begin
          staged <= RST_VAL;
          active <= RST_VAL;
          pend   <= 1'b0;
        end else begin
          if (fire) active <= staged;
          if (wr_hit) begin
            staged <= wr_data;
            pend   <= 1'b1;
          end else if (commit) begin
            pend   <= 1'b0;
          end
        end
      end

      assert_last_write_R7: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (staged == $past(wr_data)));

      assert_write_waits_R8: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> pend);

      assert_commit_value_R2: assert property (@(posedge clk) disable iff (rst)
        fire |=> (active == $past(staged)));

      assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(active));
    end
  endgenerate

endmodule

// File: rtl/shreg_update_ctrl.sv
module shreg_update_ctrl
  import shreg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 20,
  parameter int LINE_W    = 10,
  parameter int N_IMM     = 2,
  parameter int N_FRAME   = 4,
  parameter int N_SHUT    = 2,
  parameter int N_REGION  = 4,
  parameter int N_SEQ     = 4,
  parameter int SEQ_REGS  = 2,
  localparam int RGN_W    = (N_REGION > 1) ? $clog2(N_REGION) : 1,
  localparam int SEQ_W    = (N_SEQ > 1) ? $clog2(N_SEQ) : 1,
  localparam int K_FRAME  = N_IMM,
  localparam int K_SHUT   = K_FRAME + N_FRAME,
  localparam int K_REGION = K_SHUT + N_SHUT,
  localparam int K_SEQ    = K_REGION + N_REGION,
  localparam int N_REG    = K_SEQ + N_SEQ * SEQ_REGS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_valid,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    vd,
  input  logic                    hd,
  input  logic                    sg_line,
  input  logic                    scp_pulse,
  input  logic [RGN_W-1:0]        scp_region,
  output logic [N_REG*DATA_W-1:0] act_o
);

  logic [LINE_W-1:0] delay_line;
  logic              vd_fall;
  logic              sg_end;
  logic              frame_go;
  logic [DATA_W-1:0] act     [N_REG];
  logic [SEQ_W-1:0]  rgn_seq [N_REGION];
  logic [SEQ_W-1:0]  scp_seq;

  // Line-delay register: always takes effect as soon as the word lands.
  always_ff @(posedge clk) begin
    if (rst)
      delay_line <= '0;
    else if (wr_valid && wr_addr == ADDR_W'(ADDR_DELAY))
      delay_line <= wr_data[LINE_W-1:0];
  end

  assert_delay_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_addr == ADDR_W'(ADDR_DELAY)) |=> (delay_line == $past(wr_data[LINE_W-1:0])));

  shreg_events #(
    .LINE_W(LINE_W)
  ) events_i (
    .clk       (clk),
    .rst       (rst),
    .vd        (vd),
    .hd        (hd),
    .sg_line   (sg_line),
    .delay_line(delay_line),
    .vd_fall   (vd_fall),
    .sg_end    (sg_end),
    .frame_go  (frame_go)
  );

  // Region table lookup: the sequence used by the region now starting.
  always_comb begin
    for (int r = 0; r < N_REGION; r++) rgn_seq[r] = act[K_REGION + r][SEQ_W-1:0];
  end
  assign scp_seq = rgn_seq[scp_region];

  generate
    for (genvar k = 0; k < N_REG; k++) begin : g_reg
      localparam upd_cls_e CLS = cls_of(k, K_FRAME, K_SHUT, K_REGION, K_SEQ);
      localparam int       ADR = addr_of(k, K_FRAME, K_SHUT, K_REGION, K_SEQ);
      localparam logic [DATA_W-1:0] RSTV =
        (CLS == CLS_FIELD) ? DATA_W'((k - K_REGION) % N_SEQ) : '0;

      logic hit;
      logic commit;

      assign hit = wr_valid && (wr_addr == ADDR_W'(ADR));

      if (CLS == CLS_FRAME) begin : g_frame
        assign commit = frame_go;
      end else if (CLS == CLS_FIELD) begin : g_field
        assign commit = vd_fall;
      end else if (CLS == CLS_SHUT) begin : g_shut
        assign commit = sg_end;
      end else if (CLS == CLS_SEQ) begin : g_seq
        localparam int SEQ = seq_of(k, K_SEQ, SEQ_REGS);
        assign commit = scp_pulse && (scp_seq == SEQ_W'(SEQ));
      end else begin : g_now
        assign commit = 1'b0;
      end

      shreg_cell #(
        .DATA_W   (DATA_W),
        .IMMEDIATE(CLS == CLS_IMM),
        .RST_VAL  (RSTV)
      ) cell_i (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (hit),
        .wr_data(wr_data),
        .commit (commit),
        .active (act[k])
      );

      assign act_o[k*DATA_W +: DATA_W] = act[k];
    end
  endgenerate

endmodule

// File: tb/shreg_update_ctrl_tb.sv
module shreg_update_ctrl_tb_top;

  localparam int DW   = 20;
  localparam int NREG = 20;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_valid = 1'b0;
  logic [7:0]      wr_addr = '0;
  logic [DW-1:0]   wr_data = '0;
  logic            vd = 1'b1;
  logic            hd = 1'b1;
  logic            sg_line = 1'b0;
  logic            scp_pulse = 1'b0;
  logic [1:0]      scp_region = '0;
  logic [NREG*DW-1:0] act_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  shreg_update_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .vd        (vd),
    .hd        (hd),
    .sg_line   (sg_line),
    .scp_pulse (scp_pulse),
    .scp_region(scp_region),
    .act_o     (act_o)
  );

  localparam logic [2:0] OP_WR = 3'd0, OP_VD = 3'd1, OP_HD = 3'd2,
                         OP_SG = 3'd3, OP_SCP = 3'd4, OP_CHK = 3'd5;

  typedef struct packed {
    logic [2:0]    op;
    logic [7:0]    a;      // address, region, or register index for a check
    logic [DW-1:0] d;      // write data or expected value
    logic [15:0]   tag;    // requirement named in a check
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VEC [NV] = '{
    '{OP_WR,  8'h00, 20'h11111, "R1"},
    '{OP_CHK, 8'd0,  20'h11111, "R1"},
    '{OP_WR,  8'h02, 20'hAAAAA, "R2"},
    '{OP_CHK, 8'd2,  20'h00000, "R2"},
    '{OP_VD,  8'h00, 20'h00000, "R2"},
    '{OP_CHK, 8'd2,  20'hAAAAA, "R2"},
    '{OP_WR,  8'h03, 20'h00001, "R7"},
    '{OP_WR,  8'h03, 20'h00002, "R7"},
    '{OP_VD,  8'h00, 20'h00000, "R7"},
    '{OP_CHK, 8'd3,  20'h00002, "R7"},
    '{OP_WR,  8'h18, 20'h00002, "R3"},
    '{OP_WR,  8'h04, 20'h00044, "R3"},
    '{OP_WR,  8'h10, 20'h00003, "R4"},
    '{OP_VD,  8'h00, 20'h00000, "R3"},
    '{OP_CHK, 8'd8,  20'h00003, "R4"},
    '{OP_CHK, 8'd4,  20'h00000, "R3"},
    '{OP_HD,  8'h00, 20'h00000, "R3"},
    '{OP_CHK, 8'd4,  20'h00000, "R3"},
    '{OP_HD,  8'h00, 20'h00000, "R3"},
    '{OP_CHK, 8'd4,  20'h00044, "R3"},
    '{OP_WR,  8'h04, 20'h00055, "R3"},
    '{OP_HD,  8'h00, 20'h00000, "R3"},
    '{OP_HD,  8'h00, 20'h00000, "R3"},
    '{OP_CHK, 8'd4,  20'h00044, "R3"},
    '{OP_WR,  8'h18, 20'h00000, "R2"},
    '{OP_VD,  8'h00, 20'h00000, "R2"},
    '{OP_CHK, 8'd4,  20'h00055, "R2"},
    '{OP_WR,  8'h08, 20'h00088, "R5"},
    '{OP_HD,  8'h00, 20'h00000, "R5"},
    '{OP_CHK, 8'd6,  20'h00000, "R5"},
    '{OP_SG,  8'h00, 20'h00000, "R5"},
    '{OP_CHK, 8'd6,  20'h00088, "R5"},
    '{OP_WR,  8'h26, 20'h00066, "R6"},
    '{OP_SCP, 8'd1,  20'h00000, "R6"},
    '{OP_CHK, 8'd18, 20'h00000, "R6"},
    '{OP_SCP, 8'd0,  20'h00000, "R6"},
    '{OP_CHK, 8'd18, 20'h00066, "R6"},
    '{OP_WR,  8'h22, 20'h00022, "R6"},
    '{OP_SCP, 8'd0,  20'h00000, "R6"},
    '{OP_CHK, 8'd14, 20'h00000, "R6"},
    '{OP_SCP, 8'd1,  20'h00000, "R6"},
    '{OP_CHK, 8'd14, 20'h00022, "R6"},
    '{OP_WR,  8'h01, 20'h0ABCD, "R1"},
    '{OP_CHK, 8'd1,  20'h0ABCD, "R1"},
    '{OP_CHK, 8'd0,  20'h11111, "R10"},
    '{OP_CHK, 8'd19, 20'h00000, "R10"}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_valid = 1'b0; vd = 1'b1; hd = 1'b1; sg_line = 1'b0; scp_pulse = 1'b0;
  endtask

  function automatic logic [DW-1:0] reg_at(int k);
    return act_o[k*DW +: DW];
  endfunction

  task automatic check(int k, logic [DW-1:0] exp, string req);
    total++;
    if (reg_at(k) !== exp) begin
      bad++;
      $display("FAIL %s reg %0d: actual=%h expected=%h", req, k, reg_at(k), exp);
    end
  endtask

  task automatic check_defaults(string req);
    for (int k = 0; k < NREG; k++) begin
      logic [DW-1:0] e;
      e = (k >= 8 && k < 12) ? DW'(k - 8) : '0;
      check(k, e, req);
    end
  endtask

  task automatic pulse_reset();
    rst = 1'b1; idle(); tick(); tick(); rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick(); rst = 1'b0; tick();
    check_defaults("R9 R10");

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      case (v.op)
        OP_CHK: check(int'(v.a), v.d, string'(v.tag));
        OP_WR:  begin wr_valid = 1'b1; wr_addr = v.a; wr_data = v.d; tick(); idle(); tick(); end
        OP_VD:  begin vd = 1'b0; tick(); idle(); tick(); end
        OP_HD:  begin hd = 1'b0; tick(); idle(); tick(); end
        OP_SG:  begin hd = 1'b0; sg_line = 1'b1; tick(); idle(); tick(); end
        OP_SCP: begin scp_pulse = 1'b1; scp_region = v.a[1:0]; tick(); idle(); tick(); end
        default: ;
      endcase
    end

    // R8: a write landing with the frame edge waits for the following edge.
    wr_valid = 1'b1; wr_addr = 8'h02; wr_data = 20'h12345; tick(); idle(); tick();
    wr_valid = 1'b1; wr_addr = 8'h02; wr_data = 20'h54321; vd = 1'b0; tick(); idle(); tick();
    check(2, 20'h12345, "R8");
    vd = 1'b0; tick(); idle(); tick();
    check(2, 20'h54321, "R8");

    // R8 on a sequence register: write and its SCP in the same cycle.
    wr_valid = 1'b1; wr_addr = 8'h23; wr_data = 20'h0BEEF;
    scp_pulse = 1'b1; scp_region = 2'd1; tick(); idle(); tick();
    check(15, 20'h00000, "R8");
    scp_pulse = 1'b1; scp_region = 2'd1; tick(); idle(); tick();
    check(15, 20'h0BEEF, "R8");

    // R9: reset restores defaults and drops a pending write.
    wr_valid = 1'b1; wr_addr = 8'h05; wr_data = 20'h00777; tick(); idle(); tick();
    pulse_reset(); tick();
    check_defaults("R9");
    vd = 1'b0; tick(); idle(); tick();
    check(5, 20'h00000, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule